// File: doc/BRIEF.md
# Watchpoint Condition Qualifier

This block sits behind the address comparators of a debug unit. Each watchpoint slot presents a raw hit: its address and access type already matched. The qualifier decides whether that hit really fires. It reads the slot's control word and checks it against the current exception level and the secure-state flag. When the slot is linked, it also requires a context-aware breakpoint comparator to match the current 32-bit context ID.

The result is a per-slot fire vector, registered once. The core's exception logic can consume it directly.

All control and value words are expected to come from registers that are stable around the access being qualified. The breakpoint and context-comparator counts come from the debug ID word, so a linked slot can only select a comparator that exists and is context-aware.

Top module: `wp_qualifier`

## Requirements
- R1: `qualMatch` is cleared while `rst_n` is low, including asynchronously in the middle of a run. Otherwise it shows the qualification of the inputs sampled at the previous rising clock edge.
- R2: A slot whose raw hit is 0, or whose control word has enable bit 0 clear, never fires.
- R3: The security control is bits 15:14 of the control word. Value 0 passes in either state. Values 1 and 3 block the slot when `secureState` is 1. Value 2 blocks it when `secureState` is 0.
- R4: The level check depends on `curLevel`. At level 2 or 3 the slot fires only if bit 13 is set. At level 1 it needs bit 1 set. At level 0 it needs bit 2 set.
- R5: When bit 20 (link type) is 0, the breakpoint registers, the debug ID word and the context ID have no effect on the slot.
- R6: When bit 20 is 1, bits 19:16 select a breakpoint. Let B be `debugId[27:24]` and C be `debugId[23:20]`, both stored as count minus one. The selection passes only if index ≤ B and index ≥ B − C. Otherwise the slot does not fire.
- R7: A linked slot fires only if the selected breakpoint's control word has bit 0 (enable) set.
- R8: A linked slot fires only if the selected breakpoint's type field (bits 23:20) equals 3. Values 5, 9, 11 and every other value block it.
- R9: A linked slot never fires while `curLevel` is 2 or 3.
- R10: A linked slot fires only if `contextId` equals all 32 bits of the selected breakpoint's value word.
- R11: Every slot is qualified independently of the other slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rawHit | input | NUM_WP | Per-slot address/access-type match |
| wpCtrl | input | 32*NUM_WP | Watchpoint control words, slot i at bits 32i+31:32i |
| bpCtrl | input | 32*NUM_BP | Breakpoint control words |
| bpValue | input | 32*NUM_BP | Breakpoint value words (low 32 bits) |
| debugId | input | 32 | Debug ID word holding the comparator counts |
| curLevel | input | 2 | Current exception level 0..3 |
| secureState | input | 1 | 1 when executing in secure state |
| contextId | input | 32 | Current context ID |
| qualMatch | output | NUM_WP | Registered per-slot qualified match |

## Verification
The bench walks the comparator window to both of its edges. It picks indices one below the window floor and one above the count, and it also narrows the window to a single comparator. An off-by-one in the window arithmetic then shows up as a linked slot that fires or stays silent at the wrong index.

It drives every security-control value in both security states, and every exception level against slots that each set only one privilege bit. This exposes a swapped privilege bit or an inverted security code.

For linked slots it covers the following cases:
- a disabled comparator;
- the reserved type codes;
- a linked slot at levels 2 and 3;
- a single-bit context mismatch in the top bit.

A design that compared only part of the context ID, or accepted another link type, would then fire where it must not.

A final mid-run reset checks that the output clears at once.

// File: rtl/wpq_pkg.sv
package wpq_pkg;

  localparam int WORD_W   = 32;
  localparam int LINK_W   = 4;
  localparam int LINK_SPAN = 1 << LINK_W;

  // watchpoint control word field positions
  localparam int WC_EN    = 0;
  localparam int WC_PAC_LO = 1;
  localparam int WC_HMC   = 13;
  localparam int WC_SSC_LO = 14;
  localparam int WC_LBN_LO = 16;
  localparam int WC_WT    = 20;

  // breakpoint control word field positions
  localparam int BC_EN    = 0;
  localparam int BC_BT_LO = 20;

  // debug id word field positions
  localparam int DID_CTX_LO = 20;
  localparam int DID_BRP_LO = 24;

  localparam logic [3:0] BT_LINKED_CTX = 4'd3;

  typedef struct packed {
    logic              slotEn;
    logic              secPass;
    logic              lvlPass;
    logic              linked;
    logic [LINK_W-1:0] linkIdx;
  } slot_strobe_t;

endpackage

// File: rtl/wpq_ctrl.sv
module wpq_ctrl
  import wpq_pkg::*;
#(
  parameter int NUM_WP = 4
) (
  input  logic [NUM_WP*WORD_W-1:0] wpCtrl,
  input  logic [1:0]               curLevel,
  input  logic                     secureState,
  output slot_strobe_t [NUM_WP-1:0] strobes
);

  for (genvar i = 0; i < NUM_WP; i++) begin : gSlot
    logic [WORD_W-1:0] cw;
    logic [1:0]        pac;
    logic [1:0]        ssc;
    logic              hmc;
    logic              secOk;
    logic              lvlOk;
    logic              unusedCw;

    assign cw  = wpCtrl[i*WORD_W +: WORD_W];
    assign pac = cw[WC_PAC_LO +: 2];
    assign ssc = cw[WC_SSC_LO +: 2];
    assign hmc = cw[WC_HMC];
    assign unusedCw = ^{cw[WORD_W-1:WC_WT+1], cw[WC_HMC-1:WC_PAC_LO+2]};

    always_comb begin
      unique case (ssc)
        2'd0:    secOk = 1'b1;
        2'd2:    secOk = secureState;
        default: secOk = !secureState;
      endcase
    end

    always_comb begin
      unique case (curLevel)
        2'd0:    lvlOk = pac[1];
        2'd1:    lvlOk = pac[0];
        default: lvlOk = hmc;
      endcase
    end

    assign strobes[i].slotEn  = cw[WC_EN];
    assign strobes[i].secPass = secOk;
    assign strobes[i].lvlPass = lvlOk;
    assign strobes[i].linked  = cw[WC_WT];
    assign strobes[i].linkIdx = cw[WC_LBN_LO +: LINK_W];
  end

endmodule

// File: rtl/wpq_bpcmp.sv
module wpq_bpcmp
  import wpq_pkg::*;
#(
  parameter int NUM_BP = 16
) (
  input  logic [NUM_BP*WORD_W-1:0] bpCtrl,
  input  logic [NUM_BP*WORD_W-1:0] bpValue,
  input  logic [WORD_W-1:0]        debugId,
  input  logic [1:0]               curLevel,
  input  logic [WORD_W-1:0]        contextId,
  output logic [NUM_BP-1:0]        bpPass
);

  localparam int SUM_W = LINK_W + 1;

  logic [LINK_W-1:0] brpTop;
  logic [LINK_W-1:0] ctxCnt;
  logic              lowLevel;
  logic              unusedId;

  assign brpTop   = debugId[DID_BRP_LO +: LINK_W];
  assign ctxCnt   = debugId[DID_CTX_LO +: LINK_W];
  assign lowLevel = (curLevel <= 2'd1);
  assign unusedId = ^{debugId[WORD_W-1:DID_BRP_LO+LINK_W], debugId[DID_CTX_LO-1:0]};

  for (genvar b = 0; b < NUM_BP; b++) begin : gBp
    localparam logic [SUM_W-1:0] IDX = SUM_W'(b);
    logic [WORD_W-1:0] bc;
    logic [WORD_W-1:0] bv;
    logic              inWindow;
    logic              typeOk;
    logic              unusedBc;

    assign bc = bpCtrl[b*WORD_W +: WORD_W];
    assign bv = bpValue[b*WORD_W +: WORD_W];
    assign unusedBc = ^{bc[WORD_W-1:BC_BT_LO+4], bc[BC_BT_LO-1:BC_EN+1]};

    // index must lie in [brpTop - ctxCnt, brpTop]
    assign inWindow = (IDX <= {1'b0, brpTop}) &&
                      ((IDX + {1'b0, ctxCnt}) >= {1'b0, brpTop});
    assign typeOk   = (bc[BC_BT_LO +: 4] == BT_LINKED_CTX);

    assign bpPass[b] = inWindow && bc[BC_EN] && typeOk && lowLevel &&
                       (bv == contextId);
  end

endmodule

// File: rtl/wpq_datapath.sv
module wpq_datapath
  import wpq_pkg::*;
#(
  parameter int NUM_WP = 4,
  parameter int NUM_BP = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_WP-1:0]         rawHit,
  input  slot_strobe_t [NUM_WP-1:0] strobes,
  input  logic [NUM_BP-1:0]         bpPass,
  input  logic [1:0]                curLevel,
  output logic [NUM_WP-1:0]         qualMatch
);

  logic [LINK_SPAN-1:0] bpPad;
  logic [NUM_WP-1:0]    linkOk;
  logic [NUM_WP-1:0]    nextMatch;

  // indices past the implemented comparators read as failing
  always_comb begin
    bpPad = '0;
    for (int b = 0; b < NUM_BP; b++) bpPad[b] = bpPass[b];
  end

  for (genvar i = 0; i < NUM_WP; i++) begin : gSlot
    assign linkOk[i]    = !strobes[i].linked || bpPad[strobes[i].linkIdx];
    assign nextMatch[i] = rawHit[i] && strobes[i].slotEn && strobes[i].secPass &&
                          strobes[i].lvlPass && linkOk[i];

    AST_NEEDS_RAW_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      qualMatch[i] |-> $past(rawHit[i])); // R2
    AST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      qualMatch[i] |-> $past(strobes[i].slotEn)); // R2
    AST_SECURITY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      qualMatch[i] |-> $past(strobes[i].secPass)); // R3
    AST_LEVEL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      qualMatch[i] |-> $past(strobes[i].lvlPass)); // R4
    AST_LINK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (qualMatch[i] && $past(strobes[i].linked)) |-> $past(linkOk[i])); // R6
    AST_LINK_LOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (qualMatch[i] && $past(strobes[i].linked)) |-> ($past(curLevel) <= 2'd1)); // R9
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qualMatch <= '0;
    else        qualMatch <= nextMatch;
  end

endmodule

// File: rtl/wp_qualifier.sv
module wp_qualifier
  import wpq_pkg::*;
#(
  parameter int NUM_WP = 4,
  parameter int NUM_BP = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_WP-1:0]        rawHit,
  input  logic [NUM_WP*WORD_W-1:0] wpCtrl,
  input  logic [NUM_BP*WORD_W-1:0] bpCtrl,
  input  logic [NUM_BP*WORD_W-1:0] bpValue,
  input  logic [WORD_W-1:0]        debugId,
  input  logic [1:0]               curLevel,
  input  logic                     secureState,
  input  logic [WORD_W-1:0]        contextId,
  output logic [NUM_WP-1:0]        qualMatch
);

  slot_strobe_t [NUM_WP-1:0] strobes;
  logic [NUM_BP-1:0]         bpPass;

  wpq_ctrl #(.NUM_WP(NUM_WP)) uCtrl (
    .wpCtrl     (wpCtrl),
    .curLevel   (curLevel),
    .secureState(secureState),
    .strobes    (strobes)
  );

  wpq_bpcmp #(.NUM_BP(NUM_BP)) uBpCmp (
    .bpCtrl   (bpCtrl),
    .bpValue  (bpValue),
    .debugId  (debugId),
    .curLevel (curLevel),
    .contextId(contextId),
    .bpPass   (bpPass)
  );

  wpq_datapath #(.NUM_WP(NUM_WP), .NUM_BP(NUM_BP)) uData (
    .clk      (clk),
    .rst_n    (rst_n),
    .rawHit   (rawHit),
    .strobes  (strobes),
    .bpPass   (bpPass),
    .curLevel (curLevel),
    .qualMatch(qualMatch)
  );

endmodule

// File: tb/wp_qualifier_test.sv
`timescale 1ns/1ps
module wp_qualifier_test;

  localparam int NWP = 4;
  localparam int NBP = 16;
  localparam int WATCHDOG_CYCLES = 5000;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NWP-1:0]       rawHit = '0;
  logic [NWP*32-1:0]    wpCtrl = '0;
  logic [NBP*32-1:0]    bpCtrl = '0;
  logic [NBP*32-1:0]    bpValue = '0;
  logic [31:0]          debugId = '0;
  logic [1:0]           curLevel = '0;
  logic                 secureState = 1'b0;
  logic [31:0]          contextId = '0;
  logic [NWP-1:0]       qualMatch;

  logic [31:0] wpArr [NWP];
  logic [31:0] bpcArr [NBP];
  logic [31:0] bpvArr [NBP];

  int testsRun = 0;
  int testsFailed = 0;
  int posCount = 0;
  bit done = 0;

  typedef struct {
    int             due;
    logic [NWP-1:0] exp;
    string          tag;
  } sb_item_t;

  sb_item_t sbq[$];
  sb_item_t cur;

  wp_qualifier #(.NUM_WP(NWP), .NUM_BP(NBP)) uut (
    .clk(clk), .rst_n(rst_n), .rawHit(rawHit), .wpCtrl(wpCtrl),
    .bpCtrl(bpCtrl), .bpValue(bpValue), .debugId(debugId),
    .curLevel(curLevel), .secureState(secureState),
    .contextId(contextId), .qualMatch(qualMatch)
  );

  always #5 clk = ~clk;
  always @(posedge clk) posCount <= posCount + 1;

  function automatic logic [31:0] wcw(bit en, bit [1:0] pac, bit hmc,
                                      bit [1:0] ssc, bit [3:0] lbn, bit wt);
    logic [31:0] w = '0;
    w[0] = en; w[2:1] = pac; w[13] = hmc; w[15:14] = ssc;
    w[19:16] = lbn; w[20] = wt;
    return w;
  endfunction

  function automatic logic [31:0] bcw(bit en, bit [3:0] bt);
    logic [31:0] w = '0;
    w[0] = en; w[23:20] = bt;
    return w;
  endfunction

  // expected result written from the requirements
  function automatic logic [NWP-1:0] model();
    logic [NWP-1:0] r = '0;
    for (int i = 0; i < NWP; i++) begin
      logic [31:0] w = wpArr[i];
      bit ok = rawHit[i] && w[0];
      if (w[15:14] == 2'd1 || w[15:14] == 2'd3) ok = ok && !secureState;
      if (w[15:14] == 2'd2) ok = ok && secureState;
      if (curLevel == 2'd0) ok = ok && w[2];
      else if (curLevel == 2'd1) ok = ok && w[1];
      else ok = ok && w[13];
      if (w[20]) begin
        int lbn = int'(w[19:16]);
        int top = int'(debugId[27:24]);
        int cnt = int'(debugId[23:20]);
        if (lbn > top || lbn < top - cnt || lbn >= NBP) ok = 0;
        else begin
          if (!bpcArr[lbn][0]) ok = 0;
          if (bpcArr[lbn][23:20] != 4'd3) ok = 0;
          if (curLevel > 2'd1) ok = 0;
          if (contextId != bpvArr[lbn]) ok = 0;
        end
      end
      r[i] = ok;
    end
    return r;
  endfunction

  task automatic apply(string tag);
    for (int i = 0; i < NWP; i++) wpCtrl[i*32 +: 32] = wpArr[i];
    for (int b = 0; b < NBP; b++) begin
      bpCtrl[b*32 +: 32]  = bpcArr[b];
      bpValue[b*32 +: 32] = bpvArr[b];
    end
    sbq.push_back('{due: posCount + 1, exp: model(), tag: tag});
    @(negedge clk);
  endtask

  task automatic check(logic [NWP-1:0] act, logic [NWP-1:0] exp, string tag);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: qualMatch=%b expected=%b", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].due == posCount) begin
      cur = sbq.pop_front();
      check(qualMatch, cur.exp, cur.tag);
    end
  end

  task automatic baseline();
    contextId = 32'hA5C3_0F11;
    debugId = {4'd3, 4'd15, 4'd15, 20'd0};
    for (int b = 0; b < NBP; b++) begin
      bpcArr[b] = bcw(1, 4'd3);
      bpvArr[b] = contextId;
    end
    for (int i = 0; i < NWP; i++) wpArr[i] = wcw(1, 2'd3, 1, 2'd0, 4'd0, 0);
    curLevel = 2'd0;
    secureState = 1'b0;
    rawHit = '1;
  endtask

  initial begin
    #(WATCHDOG_CYCLES * 10);
    if (!done) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    baseline();
    rawHit = '0;
    apply("R1-pre");
    sbq.delete();
    repeat (2) @(negedge clk);
    check(qualMatch, '0, "R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);

    // R2
    apply("R2 no raw hit");
    rawHit = '1; wpArr[1] = wcw(0, 2'd3, 1, 2'd0, 4'd0, 0);
    apply("R2 slot disabled");

    // R3
    baseline(); curLevel = 2'd1;
    for (int i = 0; i < NWP; i++) wpArr[i] = wcw(1, 2'd3, 0, 2'(i), 4'd0, 0);
    secureState = 1'b0; apply("R3 non-secure");
    secureState = 1'b1; apply("R3 secure");

    // R4
    baseline();
    wpArr[0] = wcw(1, 2'd1, 0, 2'd0, 4'd0, 0);
    wpArr[1] = wcw(1, 2'd2, 0, 2'd0, 4'd0, 0);
    wpArr[2] = wcw(1, 2'd0, 1, 2'd0, 4'd0, 0);
    wpArr[3] = wcw(1, 2'd3, 0, 2'd0, 4'd0, 0);
    for (int l = 0; l < 4; l++) begin
      curLevel = 2'(l);
      apply($sformatf("R4 level %0d", l));
    end

    // R5
    baseline();
    for (int b = 0; b < NBP; b++) begin bpcArr[b] = '0; bpvArr[b] = '1; end
    debugId = '0; contextId = 32'h1;
    apply("R5 unlinked ignores breakpoints");

    // R6
    baseline();
    wpArr[0] = wcw(1, 2'd3, 0, 2'd0, 4'd3, 1);
    wpArr[1] = wcw(1, 2'd3, 0, 2'd0, 4'd4, 1);
    wpArr[2] = wcw(1, 2'd3, 0, 2'd0, 4'd5, 1);
    wpArr[3] = wcw(1, 2'd3, 0, 2'd0, 4'd6, 1);
    debugId = {4'd3, 4'd5, 4'd1, 20'd0}; apply("R6 window 4..5");
    debugId = {4'd3, 4'd5, 4'd0, 20'd0}; apply("R6 window 5 only");
    debugId = {4'd3, 4'd15, 4'd15, 20'd0};

    // R7
    for (int i = 0; i < NWP; i++) wpArr[i] = wcw(1, 2'd3, 1, 2'd0, 4'(i), 1);
    bpcArr[1] = bcw(0, 4'd3); apply("R7 comparator disabled");

    // R8
    bpcArr[0] = bcw(1, 4'd3);  bpcArr[1] = bcw(1, 4'd5);
    bpcArr[2] = bcw(1, 4'd9);  bpcArr[3] = bcw(1, 4'd11);
    apply("R8 reserved link types");
    bpcArr[0] = bcw(1, 4'd0);  bpcArr[1] = bcw(1, 4'd1);
    bpcArr[2] = bcw(1, 4'd15); bpcArr[3] = bcw(1, 4'd3);
    apply("R8 other link types");

    // R9
    for (int b = 0; b < NWP; b++) bpcArr[b] = bcw(1, 4'd3);
    curLevel = 2'd2; apply("R9 level 2 linked");
    curLevel = 2'd3; apply("R9 level 3 linked");
    curLevel = 2'd1; apply("R9 level 1 linked");

    // R10
    bpvArr[2] = contextId ^ 32'h8000_0000; apply("R10 top bit mismatch");
    contextId = 32'h0000_0001; apply("R10 context changed");

    // R11
    baseline();
    wpArr[0] = wcw(1, 2'd3, 0, 2'd0, 4'd0, 0);
    wpArr[1] = wcw(1, 2'd3, 0, 2'd0, 4'd7, 1);
    wpArr[2] = wcw(1, 2'd3, 0, 2'd0, 4'd8, 1);
    bpcArr[8] = bcw(0, 4'd3);
    rawHit = 4'b0111;
    apply("R11 mixed slots");
    apply("R11 hold");

    repeat (3) @(negedge clk);
    check(qualMatch, model(), "R11 steady");
    rst_n = 1'b0;
    #1;
    check(qualMatch, '0, "R1 async reset mid-run");
    @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule